// File: doc/BRIEF.md
# Indirect auto-incrementing register port

This block is the host-side register access unit of a bus controller. It holds 32 byte-wide internal registers behind one 5-bit pointer. The host first writes the pointer through an address strobe. It then reads or writes the selected register through a control strobe. After most control accesses the pointer moves on to the next address by itself, so a run of registers can be streamed without reloading it. The command, data and auxiliary-status addresses are the exceptions: the pointer stays on them, so a host can poll or feed them again and again.

The registers at pointer values 0x12, 0x13 and 0x14 are not separate storage. They are the high, middle and low bytes of one packed 24-bit transfer count. Register 0x00 also sets a 3-bit local bus identifier, which is brought out as an output. Accesses to the command and data addresses are passed to neighbouring logic as a one-cycle side-band pulse that carries the address, the direction and the byte. Command execution and data-phase buffering are handled elsewhere.

Top module: `irp_top`

## Requirements
- R1: An address-port write loads the pointer with bits [4:0] of the written byte and never increments it.
- R2: After a control-port read or write the pointer advances by one (0x1E goes to 0x1F), except when it points at 0x18 (command), 0x19 (data) or 0x1F (auxiliary status), where it holds.
- R3: Addresses 0x12, 0x13 and 0x14 read and write bits [23:16], [15:8] and [7:0] of a single 24-bit transfer count.
- R4: A control write at any other address from 0x00 to 0x16 stores the byte. A write at 0x17 or at 0x1A to 0x1E is dropped, but the pointer still advances.
- R5: A control write at address 0x00 stores the byte and puts its bits [2:0] on the own-ID output.
- R6: After reset, registers 0x00 to 0x1A and the transfer count read 0x00, registers 0x1B to 0x1E read 0xFF, 0x1F reads 0x80, the pointer is 0, the own ID is 0, the read data is 0 and there is no side-band pulse.
- R7: A control write at 0x1F is ignored: the register keeps reading 0x80 and the pointer holds.
- R8: Read data is registered. It shows the selected register in the cycle after the read strobe and holds until the next accepted read.
- R9: A control write at 0x18 or 0x19 stores the byte for readback. Any accepted control access at 0x18 or 0x19 gives a one-cycle side-band pulse in the next cycle, with the address, the direction (1 = write) and the written or read byte.
- R10: When several strobes arrive in the same cycle, the address write wins over the control write, and the control write wins over the control read. A strobe that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_we | input | 1 | Address-port write strobe |
| host_wr | input | 1 | Control-port write strobe |
| host_rd | input | 1 | Control-port read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| own_id | output | 3 | Local bus identifier |
| side_valid | output | 1 | Side-band access pulse |
| side_write | output | 1 | Side-band direction, 1 = write |
| side_addr | output | 5 | Side-band register address |
| side_data | output | 8 | Side-band byte |

## Verification
The bench goes after the places where the pointer stops or moves. A design that advanced on the command, data or status address would, on the next access, hit the neighbouring register instead of polling the same one. A design that skipped the advance at the dropped addresses 0x17 and 0x1A to 0x1E would leave the next streamed write in the wrong place. The bench drives address bytes with the top bits set, to catch a pointer that keeps more than five bits. It writes the three count bytes in a mixed order, to catch a byte-lane swap. It also fires all three strobes in one cycle, which exposes a design that lets the losing strobe store a byte or move the pointer.

// File: rtl/irp_pkg.sv
package irp_pkg;
    localparam int DW   = 8;
    localparam int AW   = 5;
    localparam int NREG = 1 << AW;
    localparam int TCB  = 3;
    localparam int TCW  = DW * TCB;
    localparam int IDW  = 3;

    localparam logic [AW-1:0] A_OWN     = 5'h00;
    localparam logic [AW-1:0] A_TC_HI   = 5'h12;
    localparam logic [AW-1:0] A_LAST_RW = 5'h16;
    localparam logic [AW-1:0] A_CMD     = 5'h18;
    localparam logic [AW-1:0] A_DATA    = 5'h19;
    localparam logic [AW-1:0] A_ONES_LO = 5'h1B;
    localparam logic [AW-1:0] A_AUX     = 5'h1F;
    localparam logic [DW-1:0] AUX_INIT  = 8'h80;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [TCW-1:0]          tc;
        logic [AW-1:0]           ptr;
        logic [IDW-1:0]          own;
        logic [DW-1:0]           rdata;
        logic                    side_v;
        logic                    side_w;
        logic [AW-1:0]           side_a;
        logic [DW-1:0]           side_d;
    } irp_state_t;

    function automatic irp_state_t irp_reset_state();
        irp_state_t s;
        s = '0;
        for (int i = 0; i < NREG; i++) begin
            if (i >= int'(A_ONES_LO) && i < int'(A_AUX)) s.regs[i] = '1;
        end
        s.regs[A_AUX] = AUX_INIT;
        return s;
    endfunction
endpackage

// File: rtl/irp_ptr_step.sv
module irp_ptr_step
    import irp_pkg::*;
(
    input  logic [AW-1:0] ptr,
    input  logic          addr_we,
    input  logic          ctl_access,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] ptr_next
);
    logic hold;

    always_comb begin
        hold = (ptr == A_CMD) || (ptr == A_DATA) || (ptr == A_AUX);
        if (addr_we) begin
            ptr_next = wdata[AW-1:0];
        end else if (ctl_access && !hold) begin
            ptr_next = ptr + AW'(1);
        end else begin
            ptr_next = ptr;
        end
    end
endmodule

// File: rtl/irp_wr_decode.sv
module irp_wr_decode
    import irp_pkg::*;
(
    input  logic [AW-1:0]  ptr,
    output logic [TCB-1:0] tc_sel,
    output logic           store_en,
    output logic           own_hit,
    output logic           side_hit
);
    genvar k;
    generate
        for (k = 0; k < TCB; k++) begin : g_tc
            // byte lane k of the count sits at A_TC_HI + (TCB-1-k)
            assign tc_sel[k] = (ptr == A_TC_HI + AW'(TCB - 1 - k));
        end
    endgenerate

    always_comb begin
        side_hit = (ptr == A_CMD) || (ptr == A_DATA);
        own_hit  = (ptr == A_OWN);
        store_en = ((ptr <= A_LAST_RW) && (tc_sel == '0)) || side_hit;
    end
endmodule

// File: rtl/irp_rd_sel.sv
module irp_rd_sel
    import irp_pkg::*;
(
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [TCW-1:0]          tc,
    input  logic [TCB-1:0]          tc_sel,
    input  logic [AW-1:0]           ptr,
    output logic [DW-1:0]           rd_val
);
    always_comb begin
        rd_val = regs[ptr];
        for (int k = 0; k < TCB; k++) begin
            if (tc_sel[k]) rd_val = tc[k*DW +: DW];
        end
    end
endmodule

// File: rtl/irp_top.sv
module irp_top
    import irp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_addr_we,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [7:0]     host_wdata,
    output logic [7:0]     host_rdata,
    output logic [2:0]     own_id,
    output logic           side_valid,
    output logic           side_write,
    output logic [4:0]     side_addr,
    output logic [7:0]     side_data
);
    irp_state_t s_d, s_q;

    logic [AW-1:0]  ptr_q;
    logic [AW-1:0]  ptr_next;
    logic [TCB-1:0] tc_sel;
    logic           store_en, own_hit, side_hit;
    logic [DW-1:0]  rd_val;
    logic           do_wr, do_rd;

    assign ptr_q = s_q.ptr;
    assign do_wr = host_wr && !host_addr_we;
    assign do_rd = host_rd && !host_addr_we && !host_wr;

    irp_ptr_step u_step (
        .ptr        (s_q.ptr),
        .addr_we    (host_addr_we),
        .ctl_access (do_wr || do_rd),
        .wdata      (host_wdata),
        .ptr_next   (ptr_next)
    );

    irp_wr_decode u_dec (
        .ptr      (s_q.ptr),
        .tc_sel   (tc_sel),
        .store_en (store_en),
        .own_hit  (own_hit),
        .side_hit (side_hit)
    );

    irp_rd_sel u_rd (
        .regs   (s_q.regs),
        .tc     (s_q.tc),
        .tc_sel (tc_sel),
        .ptr    (s_q.ptr),
        .rd_val (rd_val)
    );

    always_comb begin
        s_d        = s_q;
        s_d.side_v = 1'b0;
        s_d.ptr    = ptr_next;
        if (do_wr) begin
            for (int k = 0; k < TCB; k++) begin
                if (tc_sel[k]) s_d.tc[k*DW +: DW] = host_wdata;
            end
            if (store_en) s_d.regs[s_q.ptr] = host_wdata;
            if (own_hit)  s_d.own = host_wdata[IDW-1:0];
            if (side_hit) begin
                s_d.side_v = 1'b1;
                s_d.side_w = 1'b1;
                s_d.side_a = s_q.ptr;
                s_d.side_d = host_wdata;
            end
        end else if (do_rd) begin
            s_d.rdata = rd_val;
            if (side_hit) begin
                s_d.side_v = 1'b1;
                s_d.side_w = 1'b0;
                s_d.side_a = s_q.ptr;
                s_d.side_d = rd_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= irp_reset_state();
        else        s_q <= s_d;
    end

    assign host_rdata = s_q.rdata;
    assign own_id     = s_q.own;
    assign side_valid = s_q.side_v;
    assign side_write = s_q.side_w;
    assign side_addr  = s_q.side_a;
    assign side_data  = s_q.side_d;
endmodule

// File: rtl/irp_chk.sv
module irp_chk
    import irp_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          host_addr_we,
    input logic          host_wr,
    input logic          host_rd,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic [2:0]    own_id,
    input logic          side_valid,
    input logic [4:0]    side_addr,
    input logic [AW-1:0] ptr_q
);
    logic ctl, sticky;
    assign ctl    = (host_wr || host_rd) && !host_addr_we;
    assign sticky = (ptr_q == A_CMD) || (ptr_q == A_DATA) || (ptr_q == A_AUX);

    // R1
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr_we |=> ptr_q == $past(host_wdata[AW-1:0]));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl && sticky |=> $stable(ptr_q));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl && !sticky |=> ptr_q == $past(ptr_q) + AW'(1));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr && !host_addr_we) |=> $stable(host_rdata));

    // R5
    own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_addr_we && ptr_q == A_OWN) |=> $stable(own_id));

    // R9
    side_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        side_valid |-> (side_addr == A_CMD || side_addr == A_DATA));

    // R9
    side_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        side_valid |-> $past(ctl));
endmodule

bind irp_top irp_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr_we (host_addr_we),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .own_id       (own_id),
    .side_valid   (side_valid),
    .side_addr    (side_addr),
    .ptr_q        (ptr_q)
);

// File: tb/irp_top_bench.sv
module irp_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr_we = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [2:0] own_id;
    logic       side_valid, side_write;
    logic [4:0] side_addr;
    logic [7:0] side_data;

    int errors = 0, checks = 0;
    bit finished = 0;

    // behavioural reference
    int m_regs[32];
    int m_tc, m_ptr, m_own, m_rdata;
    int e_sv, e_sw, e_sa, e_sd;

    always #10 clk = ~clk;

    irp_top u_irp_top (
        .clk(clk), .rst_n(rst_n), .host_addr_we(host_addr_we), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .own_id(own_id), .side_valid(side_valid), .side_write(side_write),
        .side_addr(side_addr), .side_data(side_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mread(input int a);
        if (a >= 18 && a <= 20) return (m_tc >> (8 * (20 - a))) & 255;
        return m_regs[a];
    endfunction

    function automatic void mreset();
        for (int i = 0; i < 32; i++) m_regs[i] = (i >= 27 && i <= 30) ? 255 : 0;
        m_regs[31] = 128;
        m_tc = 0; m_ptr = 0; m_own = 0; m_rdata = 0;
        e_sv = 0; e_sw = 0; e_sa = 0; e_sd = 0;
    endfunction

    task automatic cyc(input bit aw, input bit wr, input bit rd, input int d, input string tag);
        bit acc, sticky;
        @(negedge clk);
        host_addr_we = aw; host_wr = wr; host_rd = rd; host_wdata = d[7:0];
        e_sv = 0;
        sticky = (m_ptr == 24) || (m_ptr == 25) || (m_ptr == 31);
        acc = !aw && (wr || rd);
        if (acc && (m_ptr == 24 || m_ptr == 25)) begin
            e_sv = 1; e_sw = wr; e_sa = m_ptr; e_sd = wr ? d : mread(m_ptr);
        end
        if (!aw && wr) begin
            if (m_ptr >= 18 && m_ptr <= 20)
                m_tc = (m_tc & ~(255 << (8 * (20 - m_ptr)))) | (d << (8 * (20 - m_ptr)));
            else if (m_ptr <= 22 || m_ptr == 24 || m_ptr == 25) m_regs[m_ptr] = d;
            if (m_ptr == 0) m_own = d & 7;
        end else if (!aw && rd) begin
            m_rdata = mread(m_ptr);
        end
        if (aw) m_ptr = d & 31;
        else if (acc && !sticky) m_ptr = (m_ptr + 1) % 32;
        @(posedge clk);
        @(negedge clk);
        host_addr_we = 0; host_wr = 0; host_rd = 0;
        check(host_rdata == m_rdata[7:0], {tag, " rdata"}, host_rdata, m_rdata);
        check(own_id == m_own[2:0], {tag, " own_id"}, own_id, m_own);
        check(side_valid == e_sv[0], {tag, " side_valid"}, side_valid, e_sv);
        if (e_sv != 0) begin
            check(side_write == e_sw[0] && side_addr == e_sa[4:0] && side_data == e_sd[7:0],
                  {tag, " side fields"}, {side_write, side_addr, side_data},
                  (e_sw << 13) | (e_sa << 8) | e_sd);
        end
    endtask

    task automatic setp(input int a, input string tag); cyc(1, 0, 0, a, tag); endtask
    task automatic wr(input int d, input string tag);   cyc(0, 1, 0, d, tag); endtask
    task automatic rd(input string tag);                cyc(0, 0, 1, 0, tag); endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        mreset();
        check(host_rdata == 0 && side_valid == 0 && own_id == 0, "R6 reset outputs",
              {side_valid, own_id, host_rdata}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        mreset();
        do_reset();
        // R6 / R2: stream every reset value; pointer 0x00..0x17 by auto-advance
        for (int i = 0; i < 24; i++) rd("R6 R2 reset stream");
        rd("R9 R2 cmd read holds");
        rd("R9 R2 cmd read holds again");
        setp(8'h3A, "R1 high bits ignored");
        for (int i = 0; i < 5; i++) rd("R6 R2 high regs to 0x1F");
        rd("R7 R2 aux reads 0x80");
        wr(8'h11, "R7 aux write ignored");
        rd("R7 aux still 0x80, pointer held");
        // R1 / R4: stream writes across the low block
        setp(8'hE1, "R1 masked load");
        for (int i = 0; i < 4; i++) wr(8'h20 + i, "R4 low block store");
        setp(8'h01, "R1 reload");
        for (int i = 0; i < 4; i++) rd("R4 low block readback");
        // R3: count lanes written out of order
        setp(8'h14, "R1"); wr(8'hC3, "R3 low lane");
        setp(8'h12, "R1"); wr(8'hA1, "R3 high lane"); wr(8'hB2, "R3 mid lane");
        setp(8'h12, "R1");
        rd("R3 read high"); rd("R3 read mid"); rd("R3 read low");
        // R4: 0x15, 0x16 store; 0x17 drop; pointer reaches 0x18
        wr(8'h55, "R4 store 0x15"); wr(8'h66, "R4 store 0x16");
        wr(8'h77, "R4 drop 0x17 advances");
        wr(8'h9C, "R9 cmd write");
        wr(8'h9D, "R9 cmd write again");
        rd("R9 cmd readback");
        setp(8'h19, "R1");
        wr(8'h42, "R9 data write"); rd("R9 data read");
        setp(8'h1A, "R1");
        for (int i = 0; i < 5; i++) wr(8'h00, "R4 drop 0x1A-0x1E advances");
        rd("R7 R2 reached 0x1F");
        setp(8'h15, "R1");
        for (int i = 0; i < 2; i++) rd("R4 0x15/0x16 readback");
        rd("R4 0x17 unchanged");
        setp(8'h1A, "R1");
        for (int i = 0; i < 5; i++) rd("R4 0x1A-0x1E unchanged");
        // R5
        setp(8'h00, "R1"); wr(8'hFD, "R5 own id 5");
        setp(8'h00, "R1"); rd("R5 own reg readback");
        wr(8'h02, "R5 write at 0x01 leaves own id");
        // R10: all strobes at once; address wins
        setp(8'h03, "R1");
        cyc(1, 1, 1, 8'h05, "R10 address wins");
        rd("R10 0x05 read");
        setp(8'h03, "R1"); rd("R10 0x03 untouched");
        setp(8'h07, "R1");
        cyc(0, 1, 1, 8'h99, "R10 write beats read");
        setp(8'h07, "R1"); rd("R10 0x07 written");
        // R8: idle cycle keeps read data
        @(negedge clk);
        check(host_rdata == m_rdata[7:0], "R8 hold while idle", host_rdata, m_rdata);
        // R6: reset mid-stream restores everything
        do_reset();
        setp(8'h12, "R1");
        rd("R6 count cleared"); rd("R6 count cleared"); rd("R6 count cleared");
        setp(8'h18, "R1"); rd("R6 cmd cleared");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule